// File: doc/BRIEF.md
# Packed Masked Funnel-Shift-Left Unit

This block is a SIMD datapath that performs a funnel shift to the left on every element of a vector of up to 512 bits. For each element position it places an element of the first source above the matching element of the second source. It shifts that double-width value left by an immediate count and keeps the upper half. Bits leave the first source at the top and are refilled from the most significant bits of the second source. The element size can be 16, 32 or 64 bits. The active vector length can be 128, 256 or 512 bits.

A per-element writemask decides which elements take the new result. When masking is on, the elements that are not written either become zero or keep the value of the prior destination, depending on a mode flag. In the wider element sizes a broadcast flag replaces the second source with its element 0 in every lane. Every destination bit above the active vector length is forced to zero. An optional register stage, on by default, captures the result when an input-valid strobe is high and raises an output-valid flag one cycle later. Decode, memory access and exception handling belong to the surrounding pipeline.

Top module: `funnel_shl_vec`

## Requirements
- R1: `esize_sel` selects the element width EW: 0 gives 16, 1 gives 32, 2 gives 64. `vlen_sel` selects the vector length VL: 0 gives 128, 1 gives 256, 2 gives 512. The lane count is VL/EW, and element j occupies bits [j*EW +: EW] of every vector port.
- R2: For each lane j, the computed value is bits [2*EW-1:EW] of ({src_hi element j, low-half element} << amt). The low-half element is src_lo element j, unless R6 applies.
- R3: The shift amount `amt` is `count` ANDed with EW-1, so the `count` bits above that are ignored. An amount of zero returns the src_hi element unchanged.
- R4: With `mask_en` low, every lane inside VL is written. With `mask_en` high, lane j is written only when `wmask[j]` is 1. Mask bits at and above the lane count have no effect.
- R5: A lane inside VL that is not written becomes zero when `zero_mode` is 1, and keeps its `dst_old` element when `zero_mode` is 0.
- R6: With `bcast` high and EW of 32 or 64, element 0 of `src_lo` is the low half in every lane. With EW of 16, `bcast` is ignored.
- R7: Output bits from VL up to bit 511 are zero, whatever the mask, mode and data inputs are.
- R8: The reserved encoding 3 of `esize_sel` or of `vlen_sel` produces an all-zero destination.
- R9: With the register stage on (default), the result is captured at a rising edge where `in_valid` is 1, and `out_valid` is 1 in the following cycle. Without `in_valid`, `out_valid` is 0 and `dst_out` holds its value. A synchronous `rst` clears both `dst_out` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the output register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid, capture the result |
| src_hi | input | 512 | First source, upper half of each funnel |
| src_lo | input | 512 | Second source, lower half of each funnel |
| dst_old | input | 512 | Prior destination value, used for merging |
| count | input | 8 | Immediate shift count |
| esize_sel | input | 2 | Element size select (0:16, 1:32, 2:64, 3:reserved) |
| vlen_sel | input | 2 | Vector length select (0:128, 1:256, 2:512, 3:reserved) |
| wmask | input | 32 | Per-element writemask, bit j for lane j |
| mask_en | input | 1 | Apply the writemask |
| zero_mode | input | 1 | 1: unwritten lanes become zero, 0: they keep their old value |
| bcast | input | 1 | Use element 0 of src_lo in every lane (32 and 64-bit only) |
| dst_out | output | 512 | Updated destination vector |
| out_valid | output | 1 | dst_out holds a new result |

## Verification
The funnel is driven with distinct pseudo-random operands at all three element widths. Because every lane carries different data, a fault in the lane slicing or in the refill from the second source shows up as a wrong word. Shift counts of zero, all-ones and counts with set upper bits tell proper masking of the count apart from use of the raw immediate. Sparse writemasks under merging and under zeroing separate the two fill policies. A mask whose upper bits are set at 128 bits checks that lanes beyond the count are ignored. Broadcast runs at each width show that element 0 is replicated for 32 and 64 bits and ignored for 16 bits.

// File: rtl/fshl_pkg.sv
package fshl_pkg;
   localparam int VEC_W   = 512;
   localparam int CHUNK_W = 16;
   localparam int N_CHUNK = VEC_W / CHUNK_W;
   localparam int N_SIZE  = 3;

   typedef enum logic [1:0] {
      ES_16  = 2'd0,
      ES_32  = 2'd1,
      ES_64  = 2'd2,
      ES_RSV = 2'd3
   } esize_e;

   typedef enum logic [1:0] {
      VL_128 = 2'd0,
      VL_256 = 2'd1,
      VL_512 = 2'd2,
      VL_RSV = 2'd3
   } vlen_e;

   // number of 16-bit chunks covered by the selected vector length
   function automatic int unsigned live_chunks(vlen_e v);
      case (v)
         VL_128:  return 8;
         VL_256:  return 16;
         VL_512:  return 32;
         default: return 0;
      endcase
   endfunction

   function automatic logic sel_legal(esize_e e, vlen_e v);
      return (e != ES_RSV) && (v != VL_RSV);
   endfunction
endpackage

// File: rtl/fshl_lane_array.sv
module fshl_lane_array #(
   parameter int EW       = 16,
   parameter int VW       = 512,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [VW-1:0]          hi_vec,
   input  logic [VW-1:0]          lo_vec,
   input  logic [$clog2(EW)-1:0]  amt,
   input  logic                   bcast,
   output logic [VW-1:0]          res_vec
);
   localparam int NL = VW / EW;

   if (VW % EW != 0) begin : g_bad_width
      $error("fshl_lane_array: VW must be a multiple of EW");
   end

   logic [VW-1:0] lo_eff;

   // variant choice: wide elements may replicate element 0 of the low source
   if (BCAST_EN) begin : g_bcast
      for (genvar j = 0; j < NL; j++) begin : g_sel
         assign lo_eff[j*EW +: EW] = bcast ? lo_vec[EW-1:0] : lo_vec[j*EW +: EW];
      end
   end else begin : g_nobcast
      wire unused_bcast = bcast;
      assign lo_eff = lo_vec;
   end

   for (genvar j = 0; j < NL; j++) begin : g_lane
      logic [2*EW-1:0] cat;
      logic [2*EW-1:0] shifted;
      assign cat     = {hi_vec[j*EW +: EW], lo_eff[j*EW +: EW]};
      assign shifted = cat << amt;
      assign res_vec[j*EW +: EW] = shifted[2*EW-1:EW];
   end
endmodule

// File: rtl/fshl_merge.sv
module fshl_merge
   import fshl_pkg::*;
#(
   parameter int VW     = 512,
   parameter int MASK_W = 32
) (
   input  logic [VW-1:0]     raw,
   input  logic [VW-1:0]     old,
   input  esize_e            es,
   input  vlen_e             vl,
   input  logic [MASK_W-1:0] wmask,
   input  logic              mask_en,
   input  logic              zero_mode,
   output logic [VW-1:0]     merged
);
   localparam int CW = CHUNK_W;
   localparam int NC = VW / CW;

   if (MASK_W < NC) begin : g_bad_mask
      $error("fshl_merge: MASK_W must cover one bit per 16-bit lane");
   end

   logic        legal;
   int unsigned live;
   assign legal = sel_legal(es, vl);
   assign live  = live_chunks(vl);

   // each 16-bit chunk finds the mask bit of the element it belongs to
   for (genvar c = 0; c < NC; c++) begin : g_chunk
      logic mbit;
      logic wr;
      logic in_rng;

      always_comb begin
         case (es)
            ES_16:   mbit = wmask[c];
            ES_32:   mbit = wmask[c/2];
            default: mbit = wmask[c/4];
         endcase
      end

      assign wr     = !mask_en || mbit;
      assign in_rng = legal && (c < live);

      always_comb begin
         if (!in_rng)
            merged[c*CW +: CW] = '0;
         else if (wr)
            merged[c*CW +: CW] = raw[c*CW +: CW];
         else if (zero_mode)
            merged[c*CW +: CW] = '0;
         else
            merged[c*CW +: CW] = old[c*CW +: CW];
      end
   end
endmodule

// File: rtl/fshl_out_stage.sv
module fshl_out_stage #(
   parameter int W       = 512,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         d_valid,
   input  logic [W-1:0] d,
   output logic         q_valid,
   output logic [W-1:0] q
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
         end else begin
            q_valid <= d_valid;
            if (d_valid) q <= d;
         end
      end
   end else begin : g_comb
      wire unused_clk = clk ^ rst;
      assign q       = d;
      assign q_valid = d_valid;
   end
endmodule

// File: rtl/funnel_shl_vec.sv
module funnel_shl_vec
   import fshl_pkg::*;
#(
   parameter int MASK_W  = 32,
   parameter int CNT_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [511:0]      src_hi,
   input  logic [511:0]      src_lo,
   input  logic [511:0]      dst_old,
   input  logic [CNT_W-1:0]  count,
   input  logic [1:0]        esize_sel,
   input  logic [1:0]        vlen_sel,
   input  logic [MASK_W-1:0] wmask,
   input  logic              mask_en,
   input  logic              zero_mode,
   input  logic              bcast,
   output logic [511:0]      dst_out,
   output logic              out_valid
);
   localparam int MAX_SH = 6;

   if (CNT_W < MAX_SH) begin : g_bad_cnt
      $error("funnel_shl_vec: CNT_W must hold a 64-bit shift amount");
   end
   if (MASK_W < N_CHUNK) begin : g_bad_mask
      $error("funnel_shl_vec: MASK_W too narrow for 16-bit lanes");
   end

   esize_e es;
   vlen_e  vl;
   assign es = esize_e'(esize_sel);
   assign vl = vlen_e'(vlen_sel);

   if (CNT_W > MAX_SH) begin : g_cnt_hi
      wire unused_cnt_hi = ^count[CNT_W-1:MAX_SH];
   end

   logic [VEC_W-1:0] raw [N_SIZE];

   // one lane array per element size, all fed in parallel
   for (genvar g = 0; g < N_SIZE; g++) begin : g_size
      localparam int EW = 16 << g;
      fshl_lane_array #(
         .EW       (EW),
         .VW       (VEC_W),
         .BCAST_EN (g != 0)
      ) u_lanes (
         .hi_vec  (src_hi),
         .lo_vec  (src_lo),
         .amt     (count[$clog2(EW)-1:0]),
         .bcast   (bcast),
         .res_vec (raw[g])
      );
   end

   logic [VEC_W-1:0] raw_sel;
   always_comb begin
      case (es)
         ES_16:   raw_sel = raw[0];
         ES_32:   raw_sel = raw[1];
         ES_64:   raw_sel = raw[2];
         default: raw_sel = '0;
      endcase
   end

   logic [VEC_W-1:0] merged;
   fshl_merge #(
      .VW     (VEC_W),
      .MASK_W (MASK_W)
   ) u_merge (
      .raw       (raw_sel),
      .old       (dst_old),
      .es        (es),
      .vl        (vl),
      .wmask     (wmask),
      .mask_en   (mask_en),
      .zero_mode (zero_mode),
      .merged    (merged)
   );

   fshl_out_stage #(
      .W       (VEC_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk     (clk),
      .rst     (rst),
      .d_valid (in_valid),
      .d       (merged),
      .q_valid (out_valid),
      .q       (dst_out)
   );
endmodule

// File: rtl/fshl_chk.sv
module fshl_chk #(
   parameter int MASK_W  = 32,
   parameter int CNT_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [511:0]      src_hi,
   input logic [511:0]      dst_old,
   input logic [CNT_W-1:0]  count,
   input logic [1:0]        esize_sel,
   input logic [1:0]        vlen_sel,
   input logic [MASK_W-1:0] wmask,
   input logic              mask_en,
   input logic              zero_mode,
   input logic [511:0]      dst_out,
   input logic              out_valid
);
   if (REG_OUT) begin : g_props
      // R9: valid follows the strobe by one cycle
      assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !out_valid);
      // R9: output held while no strobe
      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> $stable(dst_out));
      // R9: reset leaves a cleared output
      assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
         $fell(rst) |-> (!out_valid && dst_out == '0));
      // R7: bits above a 128-bit vector are zero
      assert_upper_clear_R7: assert property (@(posedge clk) disable iff (rst)
         (in_valid && vlen_sel == 2'd0) |=> (dst_out[511:128] == '0));
      // R8: reserved size gives zero
      assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
         (in_valid && (esize_sel == 2'd3 || vlen_sel == 2'd3)) |=> (dst_out == '0));
      // R3: zero amount passes the first source
      assert_zero_amt_R3: assert property (@(posedge clk) disable iff (rst)
         (in_valid && esize_sel == 2'd0 && vlen_sel == 2'd2 && !mask_en && count[3:0] == 4'd0)
         |=> (dst_out == $past(src_hi)));
      // R5: empty mask under merging keeps the old value
      assert_merge_keep_R5: assert property (@(posedge clk) disable iff (rst)
         (in_valid && mask_en && !zero_mode && wmask == '0 && vlen_sel == 2'd2 && esize_sel != 2'd3)
         |=> (dst_out == $past(dst_old)));
      // R5: empty mask under zeroing clears everything
      assert_zeroing_R5: assert property (@(posedge clk) disable iff (rst)
         (in_valid && mask_en && zero_mode && wmask == '0) |=> (dst_out == '0));
   end else begin : g_noprops
      wire unused_chk = ^{clk, rst, in_valid, src_hi, dst_old, count, esize_sel,
                          vlen_sel, wmask, mask_en, zero_mode, dst_out, out_valid};
   end
endmodule

bind funnel_shl_vec fshl_chk #(
   .MASK_W  (MASK_W),
   .CNT_W   (CNT_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .src_hi    (src_hi),
   .dst_old   (dst_old),
   .count     (count),
   .esize_sel (esize_sel),
   .vlen_sel  (vlen_sel),
   .wmask     (wmask),
   .mask_en   (mask_en),
   .zero_mode (zero_mode),
   .dst_out   (dst_out),
   .out_valid (out_valid)
);

// File: tb/sim_funnel_shl_vec.sv
`timescale 1ns/1ps
module sim_funnel_shl_vec;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [511:0] src_hi = '0, src_lo = '0, dst_old = '0;
   logic [7:0]   count = '0;
   logic [1:0]   esize_sel = '0, vlen_sel = '0;
   logic [31:0]  wmask = '0;
   logic         mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0;
   logic [511:0] dst_out;
   logic         out_valid;

   int checks = 0;
   int errors = 0;
   int pushed = 0;
   int popped = 0;
   bit done   = 1'b0;

   logic [511:0] exp_q[$];
   string        tag_q[$];
   logic [511:0] last_exp = '0;

   always #10 clk = ~clk;

   funnel_shl_vec u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .src_hi(src_hi), .src_lo(src_lo), .dst_old(dst_old),
      .count(count), .esize_sel(esize_sel), .vlen_sel(vlen_sel),
      .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
      .dst_out(dst_out), .out_valid(out_valid)
   );

   function automatic logic [511:0] pat(input int unsigned seed);
      logic [511:0] v = '0;
      int unsigned  x = seed * 32'h9E37_79B9 + 32'd7;
      for (int i = 0; i < 16; i++) begin
         x = x * 32'd1664525 + 32'd1013904223;
         v[i*32 +: 32] = x;
      end
      return v;
   endfunction

   // expected result from the requirements (R1..R8)
   function automatic logic [511:0] model(
      input logic [511:0] hi, lo, old, input logic [7:0] cnt,
      input logic [1:0] es, vl, input logic [31:0] wm,
      input logic men, zm, bc);
      logic [511:0] res = '0;
      logic [127:0] m, h, l, t, r, o, val;
      int ew, nl, amt;
      if (es == 2'd3 || vl == 2'd3) return '0;
      ew  = 16 << es;
      nl  = (128 << vl) / ew;
      amt = int'(cnt) & (ew - 1);
      m   = (128'd1 << ew) - 128'd1;
      for (int j = 0; j < nl; j++) begin
         h = 128'(hi >> (j*ew)) & m;
         l = (bc && es != 2'd0) ? (128'(lo) & m) : (128'(lo >> (j*ew)) & m);
         o = 128'(old >> (j*ew)) & m;
         t = ((h << ew) | l) << amt;
         r = (t >> ew) & m;
         val = (!men || wm[j]) ? r : (zm ? 128'd0 : o);
         res = res | (512'(val) << (j*ew));
      end
      return res;
   endfunction

   task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input string tag, input logic [511:0] hi, lo, old,
                        input logic [7:0] cnt, input logic [1:0] es, vl,
                        input logic [31:0] wm, input logic men, zm, bc);
      src_hi = hi; src_lo = lo; dst_old = old; count = cnt;
      esize_sel = es; vlen_sel = vl; wmask = wm;
      mask_en = men; zero_mode = zm; bcast = bc; in_valid = 1'b1;
      exp_q.push_back(model(hi, lo, old, cnt, es, vl, wm, men, zm, bc));
      tag_q.push_back(tag);
      pushed++;
      @(negedge clk);
   endtask

   // monitor: pops expected results as valid outputs appear
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R9 unexpected valid", {511'd0, out_valid}, 512'd0);
         end else begin
            logic [511:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            popped++;
            last_exp = e;
            check(t, dst_out, e);
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [511:0] a, b, d, c5, c6;
      a = pat(1); b = pat(2); d = pat(3); c5 = pat(4); c6 = pat(5);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R9 reset data", dst_out, '0);
      check("R9 reset valid", {511'd0, out_valid}, 512'd0);

      drive("R2 16-bit funnel", a, b, d, 8'd5,  2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R2 32-bit funnel", a, b, d, 8'd13, 2'd1, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R2 64-bit funnel", a, b, d, 8'd37, 2'd2, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R3 zero amount",   a, b, d, 8'd0,  2'd1, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R3 count EF on 16", a, b, d, 8'hEF, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R3 count FF on 64", a, b, d, 8'hFF, 2'd2, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R3 count 40 on 32", a, b, d, 8'h40, 2'd1, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R4 sparse merge",  a, b, d, 8'd9,  2'd1, 2'd2, 32'h0000_A5C3, 1'b1, 1'b0, 1'b0);
      drive("R4 mask off",      a, b, d, 8'd9,  2'd2, 2'd2, 32'h0, 1'b0, 1'b1, 1'b0);
      drive("R4 upper mask ignored", a, b, d, 8'd3, 2'd2, 2'd0, 32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0);
      drive("R5 zeroing",       a, b, d, 8'd7,  2'd0, 2'd2, 32'h1234_F0F0, 1'b1, 1'b1, 1'b0);
      drive("R5 merging",       a, b, d, 8'd7,  2'd0, 2'd2, 32'h1234_F0F0, 1'b1, 1'b0, 1'b0);
      drive("R5 empty mask merge", a, b, d, 8'd2, 2'd2, 2'd2, 32'h0, 1'b1, 1'b0, 1'b0);
      drive("R6 broadcast 64",  a, b, d, 8'd11, 2'd2, 2'd2, 32'h0, 1'b0, 1'b0, 1'b1);
      drive("R6 broadcast 32",  a, b, d, 8'd11, 2'd1, 2'd2, 32'h0, 1'b0, 1'b0, 1'b1);
      drive("R6 broadcast 16 ignored", a, b, d, 8'd11, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 1'b1);
      drive("R7 128-bit clear", a, b, d, 8'd4,  2'd0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R7 256-bit zeroing", a, b, d, 8'd20, 2'd1, 2'd1, 32'h0000_0055, 1'b1, 1'b1, 1'b0);
      drive("R1 32 lanes of 16", c5, c6, d, 8'd1, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R1 2 lanes of 64", c5, c6, d, 8'd60, 2'd2, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R8 reserved size", a, b, d, 8'd3,  2'd3, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R8 reserved length", a, b, d, 8'd3, 2'd1, 2'd3, 32'h0, 1'b0, 1'b0, 1'b0);
      drive("R2 last before hold", c6, c5, a, 8'd17, 2'd1, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0);

      // R9: with the strobe low, changing operands must not reach the output
      in_valid = 1'b0;
      src_hi = d; src_lo = a; count = 8'd3;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check("R9 hold data", dst_out, last_exp);
      check("R9 no valid without strobe", {511'd0, out_valid}, 512'd0);
      check("R9 every result seen", 512'(popped), 512'(pushed));

      // R9: synchronous reset clears a loaded output
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R9 reset clears data", dst_out, '0);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule